// File: doc/BRIEF.md
# Reset-Level Clamp Strobe Sequencer

This block produces two single-cycle digital strobes for a CCD analog front-end timing controller. The first is a clamp strobe that tells the analog input stage to clamp the pixel's reset level. The second is a reset-sample strobe that tells the correlated sampling stage when to take its reference. Both are timed from the master clock and from the video sample pulse, which marks one pixel per pulse. On the first master-clock edge inside each sample pulse, the block captures a clamp request. The request comes from an external request pin, or from an internal register bit when auto-cycle mode is selected. The captured value then decides whether the clamp strobe is issued on the reset level that follows the end of that pulse.

A 2-bit position field sets how many master-clock cycles after the end of the sample pulse the strobes appear. A reference-enable bit, set by default, turns the reset-sample strobe on or off. The position field, the reference-enable bit, the auto-cycle selector and the internal request bit are all taken once per pixel, at the start of the sample pulse. A strobe that is already scheduled therefore always keeps the settings it was scheduled with.

Top module: `clamp_seq`

## Requirements
- R1: The clamp request is captured on the clock edge at which `vsmp_i` is first sampled high after having been sampled low. This edge is the pixel's capture edge.
- R2: When `auto_cyc_i` is 1 at the capture edge, the captured request is `clamp_int_i` and `clamp_pin_i` has no effect. When `auto_cyc_i` is 0, the captured request is `clamp_pin_i`.
- R3: A captured request of 1 produces one `clamp_o` pulse after the pulse ends. A captured request of 0 produces no `clamp_o` pulse for that pixel.
- R4: Let E be the first edge at which `vsmp_i` is sampled low after the pulse. The strobes become high on edge E+P, where P is the unsigned value of `pos_sel_i` (00→0, 01→1, 10→2, 11→3).
- R5: Every `clamp_o` or `rs_o` pulse is high for exactly one clock cycle.
- R6: When `ref_en_i` is 1 at the capture edge, `rs_o` pulses at the R4 position whether or not a clamp was requested. When it is 0, `rs_o` stays low for that pixel.
- R7: Changes to `pos_sel_i`, `ref_en_i`, `auto_cyc_i` and `clamp_int_i` after the capture edge do not affect that pixel's strobes.
- R8: While `rst_n` is low, both strobes are low and the captured request is cleared. After reset, no strobe appears until a sample pulse has been seen.
- R9: Later clock edges inside the same high pulse do not recapture the request. A request-pin change after the capture edge leaves the pixel's clamp decision unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| vsmp_i | input | 1 | Video sample pulse, one per pixel |
| clamp_pin_i | input | 1 | External clamp request |
| auto_cyc_i | input | 1 | Auto-cycle mode: 1 selects the internal request bit |
| clamp_int_i | input | 1 | Internal clamp request register bit |
| pos_sel_i | input | 2 | Strobe position after the end of the sample pulse |
| ref_en_i | input | 1 | Reset-level referencing enable (reset value of the register is 1) |
| clamp_o | output | 1 | Clamp strobe |
| rs_o | output | 1 | Reset-sample strobe |

## Verification
The hardest situation to reach is a configuration or request change that lands while a pixel is still in flight, that is, between its capture edge and its strobe. Ordinary stimulus, with settings held steady across a pixel, never exposes a block that reads its settings live. The stimulus therefore holds the sample pulse high for several cycles and flips the request pin, the auto-cycle selector, the position field and the reference enable after the capture edge. It flips the position field and reference enable again during the low gap before the strobe. A per-cycle reference model schedules each strobe by absolute cycle number and compares both outputs on every clock.

// File: rtl/clamp_seq_pkg.sv
package clamp_seq_pkg;

  localparam int unsigned POS_W = 2;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic             ref_en;
  } pix_cfg_t;

  localparam logic REF_EN_RST = 1'b1;

endpackage

// File: rtl/vsmp_edge.sv
module vsmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsmp_i,
  output logic rise_o,
  output logic fall_o
);

  logic vsmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsmp_q <= 1'b0;
    end else begin
      vsmp_q <= vsmp_i;
    end
  end

  assign rise_o = vsmp_i & ~vsmp_q;
  assign fall_o = ~vsmp_i & vsmp_q;

endmodule

// File: rtl/clamp_capture.sv
module clamp_capture
  import clamp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             clamp_pin_i,
  input  logic             auto_cyc_i,
  input  logic             clamp_int_i,
  input  logic [POS_W-1:0] pos_sel_i,
  input  logic             ref_en_i,
  output logic             req_o,
  output pix_cfg_t         cfg_o
);

  logic     req_q, req_d;
  pix_cfg_t cfg_q, cfg_d;
  logic     cap_en;

  assign cap_en = rise_i;

  always_comb begin
    req_d = req_q;
    cfg_d = cfg_q;
    if (cap_en) begin
      req_d        = auto_cyc_i ? clamp_int_i : clamp_pin_i;
      cfg_d.pos    = pos_sel_i;
      cfg_d.ref_en = ref_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q        <= 1'b0;
      cfg_q.pos    <= '0;
      cfg_q.ref_en <= REF_EN_RST;
    end else if (cap_en) begin
      req_q <= req_d;
      cfg_q <= cfg_d;
    end
  end

  assign req_o = req_q;
  assign cfg_o = cfg_q;

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import clamp_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall_i,
  input  logic     req_i,
  input  pix_cfg_t cfg_i,
  output logic     clamp_o,
  output logic     rs_o
);

  logic             armed_q, armed_d;
  logic [POS_W-1:0] cnt_q, cnt_d;
  logic             act_req_q, act_req_d;
  pix_cfg_t         act_cfg_q, act_cfg_d;
  logic             clamp_q, clamp_d;
  logic             rs_q, rs_d;
  logic             fire;
  logic             sel_req, sel_ref;

  always_comb begin
    armed_d   = armed_q;
    cnt_d     = cnt_q;
    act_req_d = act_req_q;
    act_cfg_d = act_cfg_q;
    fire      = 1'b0;
    if (fall_i) begin
      act_req_d = req_i;
      act_cfg_d = cfg_i;
      if (cfg_i.pos == '0) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
        cnt_d   = {{(POS_W-1){1'b0}}, 1'b1};
      end
    end else if (armed_q) begin
      if (cnt_q == act_cfg_q.pos) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    sel_req = fall_i ? req_i        : act_req_q;
    sel_ref = fall_i ? cfg_i.ref_en : act_cfg_q.ref_en;
    clamp_d = fire & sel_req;
    rs_d    = fire & sel_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q          <= 1'b0;
      cnt_q            <= '0;
      act_req_q        <= 1'b0;
      act_cfg_q.pos    <= '0;
      act_cfg_q.ref_en <= REF_EN_RST;
      clamp_q          <= 1'b0;
      rs_q             <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      cnt_q     <= cnt_d;
      act_req_q <= act_req_d;
      act_cfg_q <= act_cfg_d;
      clamp_q   <= clamp_d;
      rs_q      <= rs_d;
    end
  end

  assign clamp_o = clamp_q;
  assign rs_o    = rs_q;

endmodule

// File: rtl/clamp_seq.sv
module clamp_seq
  import clamp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsmp_i,
  input  logic             clamp_pin_i,
  input  logic             auto_cyc_i,
  input  logic             clamp_int_i,
  input  logic [POS_W-1:0] pos_sel_i,
  input  logic             ref_en_i,
  output logic             clamp_o,
  output logic             rs_o
);

  logic     rise, fall;
  logic     cap_req;
  pix_cfg_t cap_cfg;

  vsmp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .vsmp_i (vsmp_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  clamp_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .clamp_pin_i (clamp_pin_i),
    .auto_cyc_i  (auto_cyc_i),
    .clamp_int_i (clamp_int_i),
    .pos_sel_i   (pos_sel_i),
    .ref_en_i    (ref_en_i),
    .req_o       (cap_req),
    .cfg_o       (cap_cfg)
  );

  strobe_timer u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_i  (fall),
    .req_i   (cap_req),
    .cfg_i   (cap_cfg),
    .clamp_o (clamp_o),
    .rs_o    (rs_o)
  );

endmodule

// File: rtl/clamp_seq_chk.sv
module clamp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vsmp_i,
  input logic clamp_o,
  input logic rs_o,
  input logic cap_req
);

  logic prev_v;
  logic seen_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v   <= 1'b0;
      seen_pix <= 1'b0;
    end else begin
      prev_v   <= vsmp_i;
      seen_pix <= seen_pix | vsmp_i;
    end
  end

  // R5
  clamp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |=> !clamp_o);

  // R5
  rs_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_o |=> !rs_o);

  // R8
  no_strobe_before_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_o || rs_o) |-> seen_pix);

  // R9
  capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsmp_i && prev_v) |=> $stable(cap_req));

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!clamp_o && !rs_o && !cap_req);
    end
  end

endmodule

bind clamp_seq clamp_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vsmp_i  (vsmp_i),
  .clamp_o (clamp_o),
  .rs_o    (rs_o),
  .cap_req (cap_req)
);

// File: tb/clamp_seq_tb.sv
`timescale 1ns/1ps
module clamp_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsmp = 1'b0;
  logic       pin = 1'b0;
  logic       auto_c = 1'b0;
  logic       int_r = 1'b0;
  logic [1:0] pos = 2'd0;
  logic       ref_en = 1'b1;
  logic       clamp_o, rs_o;

  int    vectors = 0;
  int    misses = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R8";

  // reference model state
  bit m_pv = 0;
  bit m_req = 0;
  int m_pos = 0;
  bit m_ref = 1;
  bit m_pend = 0;
  int m_at = 0;
  bit m_sreq = 0;
  bit m_sref = 0;
  bit e_clamp = 0;
  bit e_rs = 0;

  always #5 clk = ~clk;

  clamp_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsmp_i      (vsmp),
    .clamp_pin_i (pin),
    .auto_cyc_i  (auto_c),
    .clamp_int_i (int_r),
    .pos_sel_i   (pos),
    .ref_en_i    (ref_en),
    .clamp_o     (clamp_o),
    .rs_o        (rs_o)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_pv = 0; m_req = 0; m_pos = 0; m_ref = 1; m_pend = 0;
      e_clamp = 0; e_rs = 0;
    end else begin
      if (vsmp && !m_pv) begin
        m_req = auto_c ? int_r : pin;
        m_pos = int'(pos);
        m_ref = ref_en;
      end
      if (!vsmp && m_pv) begin
        m_pend = 1; m_at = cyc + m_pos; m_sreq = m_req; m_sref = m_ref;
      end
      e_clamp = 0; e_rs = 0;
      if (m_pend && cyc == m_at) begin
        e_clamp = m_sreq; e_rs = m_sref; m_pend = 0;
      end
      m_pv = vsmp;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (clamp_o !== e_clamp || rs_o !== e_rs) begin
        misses++;
        $display("FAIL %s cycle %0d: clamp_o/rs_o = %b/%b, expected %b/%b",
                 tag, cyc, clamp_o, rs_o, e_clamp, e_rs);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one pixel: pin value before the capture edge, then pin_late for the rest
  task automatic pixel(input string t, input int hi, input int lo,
                       input logic pin_early, input logic pin_late);
    tag = t;
    pin = pin_early;
    @(negedge clk);
    vsmp = 1'b1;
    @(negedge clk);
    pin = pin_late;
    for (int i = 1; i < hi; i++) @(negedge clk);
    vsmp = 1'b0;
    for (int i = 0; i < lo; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R8: reset state and quiet period before any pixel
    tag = "R8";
    pin = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(6);

    // R3: clamp requested, then not requested
    auto_c = 1'b0; pos = 2'd0; ref_en = 1'b1;
    pixel("R3", 2, 6, 1'b1, 1'b1);
    pixel("R3", 2, 6, 1'b0, 1'b0);

    // R4 and R5: every position, one-cycle strobes
    for (int p = 0; p < 4; p++) begin
      pos = p[1:0];
      pixel("R4", 1, 6, 1'b1, 1'b1);
      pixel("R5", 3, 6, 1'b1, 1'b0);
    end

    // R2: auto-cycle takes internal bit, pin ignored
    auto_c = 1'b1; int_r = 1'b0; pos = 2'd1;
    pixel("R2", 2, 6, 1'b1, 1'b1);
    int_r = 1'b1;
    pixel("R2", 2, 6, 1'b0, 1'b0);
    auto_c = 1'b0;
    pixel("R2", 2, 6, 1'b0, 1'b0);

    // R6: reference strobe with and without clamp, and disabled
    pos = 2'd2; ref_en = 1'b1;
    pixel("R6", 2, 6, 1'b0, 1'b0);
    ref_en = 1'b0;
    pixel("R6", 2, 6, 1'b1, 1'b1);
    pixel("R6", 2, 6, 1'b0, 1'b0);
    ref_en = 1'b1;

    // R1: pin changes right at the capture boundary
    pos = 2'd0;
    pixel("R1", 1, 5, 1'b1, 1'b0);
    pixel("R1", 1, 5, 1'b0, 1'b1);

    // R9: long pulse, pin flips after capture
    pixel("R9", 7, 6, 1'b0, 1'b1);
    pixel("R9", 6, 6, 1'b1, 1'b0);

    // R7: settings change after capture edge and during the gap
    tag = "R7";
    auto_c = 1'b0; pos = 2'd3; ref_en = 1'b1; pin = 1'b1; int_r = 1'b0;
    @(negedge clk);
    vsmp = 1'b1;
    @(negedge clk);
    auto_c = 1'b1; pos = 2'd0; ref_en = 1'b0; int_r = 1'b0; pin = 1'b0;
    idle(2);
    vsmp = 1'b0;
    @(negedge clk);
    pos = 2'd1; ref_en = 1'b1; auto_c = 1'b0;
    idle(6);
    pos = 2'd1; ref_en = 1'b0; pin = 1'b1;
    @(negedge clk);
    vsmp = 1'b1;
    @(negedge clk);
    pos = 2'd3; ref_en = 1'b1; pin = 1'b0;
    vsmp = 1'b0;
    idle(6);

    // R8: reset in the middle of a scheduled strobe
    tag = "R8";
    pos = 2'd3; pin = 1'b1;
    @(negedge clk);
    vsmp = 1'b1;
    idle(2);
    vsmp = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule